// File: doc/BRIEF.md
# Charge Status LED Driver

This block turns the phase code of a battery charge controller into active-low drive for status indicators. A static mode input picks one of two indicator arrangements. In single-indicator mode, one line lights while charge current flows and blinks with an even duty cycle when the charger reports a fault. In two-colour mode, a red line and a green line together form one bicolour indicator: red shows charging, green shows completion, and both together (yellow) show a fault.

The blink rate comes from a clock prescaler set by the system clock frequency and the wanted blink rate. Each time the fault phase is entered, the blink restarts at the start of its lit half. Both outputs come straight from flops, so each changes cleanly on one clock edge after the phase input changes.

Top module: `chg_led_drv`

## Requirements
- R1: While reset is asserted (rst_n low), both outputs are high (unlit).
- R2: In single mode (mode_bicolor=0), led_a_n is low one edge after a phase of 1 (precharge) or 2 (fast charge) is sampled. It is high after phase 0 (sleep), 3 (done), 5 (qualification invalid), 6 (thermal shutdown) or 7 (battery absent).
- R3: In single mode, led_b_n stays high whatever the phase is.
- R4: In single mode, while phase 4 (fault) is held, led_a_n is low for HALF cycles and then high for HALF cycles, repeating. HALF = CLK_HZ / (2*BLINK_HZ).
- R5: The first fault sample after any other phase (or after reset) restarts the blink. led_a_n goes low on that edge and begins a full lit half.
- R6: In bicolour mode (mode_bicolor=1), phases 1 and 2 give led_a_n (red) low and led_b_n (green) high.
- R7: In bicolour mode, phase 4 gives both outputs low, steadily and without blinking.
- R8: In bicolour mode, phase 3 gives led_b_n low and led_a_n high.
- R9: In bicolour mode, phases 0, 5, 6 and 7 give both outputs high.
- R10: Each output is registered. It reflects the phase sampled at a rising edge from that edge on, and never changes between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bicolor | input | 1 | Static mode select: 0 = single indicator, 1 = red/green pair |
| phase | input | 3 | Charge phase code (see R2) |
| led_a_n | output | 1 | Single indicator or red line, active low |
| led_b_n | output | 1 | Green line, active low; held high in single mode |

## Verification
The hardest case to reach is a return to the fault phase in the middle of a blink. The restart has to be told apart from a counter that simply keeps running. The bench holds a fault into its unlit half, leaves for a few cycles, and comes back. It then checks that the lit half starts again at full length. Random phase sequences with random hold lengths make more such re-entries, at uneven offsets inside the blink period.

// File: rtl/chg_led_pkg.sv
package chg_led_pkg;

  typedef enum logic [2:0] {
    PH_SLEEP    = 3'd0,
    PH_PRECHG   = 3'd1,
    PH_FAST     = 3'd2,
    PH_DONE     = 3'd3,
    PH_FAULT    = 3'd4,
    PH_QUAL_BAD = 3'd5,
    PH_HOT      = 3'd6,
    PH_NO_BATT  = 3'd7
  } chg_phase_e;

  typedef struct packed {
    logic a_on;
    logic b_on;
  } led_pair_t;

  // Cycles in one half of the blink period
  function automatic int unsigned blink_half(input int unsigned clk_hz,
                                             input int unsigned blink_hz);
    int unsigned h;
    h = clk_hz / (2 * blink_hz);
    return (h == 0) ? 1 : h;
  endfunction

  // Phase to lamp mapping; returns "on" flags (active high)
  function automatic led_pair_t map_phase(input logic bicolor,
                                          input logic [2:0] ph,
                                          input logic blink_lit);
    led_pair_t r;
    logic charging;
    charging = (ph == PH_PRECHG) || (ph == PH_FAST);
    if (bicolor) begin
      r.a_on = charging || (ph == PH_FAULT);
      r.b_on = (ph == PH_DONE) || (ph == PH_FAULT);
    end else begin
      r.a_on = charging || ((ph == PH_FAULT) && blink_lit);
      r.b_on = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/chg_fault_entry.sv
module chg_fault_entry
  import chg_led_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] phase,
  output logic       entry
);
  logic [2:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PH_SLEEP;
    else        prev_q <= phase;
  end

  assign entry = (phase == PH_FAULT) && (prev_q != PH_FAULT);
endmodule

// File: rtl/chg_blink_gen.sv
module chg_blink_gen #(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic lit_nxt
);
  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             lit_q;

  always_comb begin
    if (restart) begin
      cnt_nxt = '0;
      lit_nxt = 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_nxt = '0;
      lit_nxt = ~lit_q;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
      lit_nxt = lit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lit_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      lit_q <= lit_nxt;
    end
  end
endmodule

// File: rtl/chg_led_map.sv
module chg_led_map
  import chg_led_pkg::*;
(
  input  logic       mode_bicolor,
  input  logic [2:0] phase,
  input  logic       blink_lit,
  output led_pair_t  lamps_on
);
  assign lamps_on = map_phase(mode_bicolor, phase, blink_lit);
endmodule

// File: rtl/chg_led_outreg.sv
module chg_led_outreg
  import chg_led_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  led_pair_t lamps_on,
  output logic      led_a_n,
  output logic      led_b_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_a_n <= 1'b1;
      led_b_n <= 1'b1;
    end else begin
      led_a_n <= ~lamps_on.a_on;
      led_b_n <= ~lamps_on.b_on;
    end
  end
endmodule

// File: rtl/chg_led_drv.sv
module chg_led_drv
  import chg_led_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 32768,
  parameter int unsigned BLINK_HZ = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_bicolor,
  input  logic [2:0] phase,
  output logic       led_a_n,
  output logic       led_b_n
);
  localparam int unsigned HALF_CYC = blink_half(CLK_HZ, BLINK_HZ);

  // Named internal events, visible to the bound checker
  logic      fault_entry;
  logic      blink_lit_nxt;
  led_pair_t lamps_on;

  chg_fault_entry u_entry (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .entry (fault_entry)
  );

  chg_blink_gen #(.HALF_CYC(HALF_CYC)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fault_entry),
    .lit_nxt (blink_lit_nxt)
  );

  chg_led_map u_map (
    .mode_bicolor (mode_bicolor),
    .phase        (phase),
    .blink_lit    (blink_lit_nxt),
    .lamps_on     (lamps_on)
  );

  chg_led_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .lamps_on (lamps_on),
    .led_a_n  (led_a_n),
    .led_b_n  (led_b_n)
  );
endmodule

// File: rtl/chg_led_drv_chk.sv
module chg_led_drv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_bicolor,
  input logic [2:0] phase,
  input logic       led_a_n,
  input logic       led_b_n,
  input logic       fault_entry,
  input logic       blink_lit_nxt
);
  // R1: outputs dark during reset
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_dark_r1: assert (led_a_n && led_b_n);
    end
  end

  p_single_charge_lit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_bicolor && (phase == 3'd1 || phase == 3'd2)) |=> !led_a_n);

  p_single_green_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_bicolor |=> led_b_n);

  p_single_blink_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_bicolor && phase == 3'd4) |=> (led_a_n == !$past(blink_lit_nxt)));

  p_entry_starts_lit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_bicolor && fault_entry) |=> !led_a_n);

  p_bicolor_fault_yellow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bicolor && phase == 3'd4) |=> (!led_a_n && !led_b_n));

  p_bicolor_done_green_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bicolor && phase == 3'd3) |=> (led_a_n && !led_b_n));

  p_bicolor_idle_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bicolor && (phase == 3'd0 || phase >= 3'd5)) |=> (led_a_n && led_b_n));
endmodule

bind chg_led_drv chg_led_drv_chk u_chk (.*);

// File: tb/chg_led_drv_tb.sv
module chg_led_drv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 20;
  localparam int TB_BLINK   = 1;
  localparam int HALF       = TB_CLK_HZ / (2 * TB_BLINK);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_bicolor = 1'b0;
  logic [2:0] phase = 3'd0;
  logic       led_a_n, led_b_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model state
  int         k_fault = 0;
  logic [2:0] prev_ph = 3'd0;
  logic       exp_a_n = 1'b1;
  logic       exp_b_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_led_drv #(.CLK_HZ(TB_CLK_HZ), .BLINK_HZ(TB_BLINK)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_bicolor(mode_bicolor),
    .phase(phase), .led_a_n(led_a_n), .led_b_n(led_b_n)
  );

  function automatic string auto_tag(input logic m, input logic [2:0] p,
                                     input bit is_b, input int k);
    if (!m) begin
      if (is_b) return "R3";
      if (p == 3'd4) return (k == 0) ? "R5" : "R4";
      return "R2";
    end
    if (p == 3'd1 || p == 3'd2) return "R6";
    if (p == 3'd4) return "R7";
    if (p == 3'd3) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b (mode=%b phase=%0d t=%0t)",
               tag, act, exp_v, mode_bicolor, phase, $time);
    end
  endtask

  // Called at a falling edge: apply inputs, predict the next edge, check at next fall
  task automatic cyc(input logic m, input logic [2:0] p, input string tag_ovr);
    bit lit;
    mode_bicolor = m;
    phase = p;
    if (p == 3'd4 && prev_ph != 3'd4) k_fault = 0;
    else if (p == 3'd4) k_fault++;
    prev_ph = p;
    lit = (k_fault % (2*HALF)) < HALF;
    if (m) begin
      exp_a_n = !(p == 3'd1 || p == 3'd2 || p == 3'd4);
      exp_b_n = !(p == 3'd3 || p == 3'd4);
    end else begin
      exp_a_n = !(p == 3'd1 || p == 3'd2 || (p == 3'd4 && lit));
      exp_b_n = 1'b1;
    end
    @(negedge clk);
    check((tag_ovr != "") ? tag_ovr : auto_tag(m, p, 1'b0, k_fault), led_a_n, exp_a_n);
    check((tag_ovr != "") ? tag_ovr : auto_tag(m, p, 1'b1, k_fault), led_b_n, exp_b_n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    phase = 3'd0;
    @(negedge clk);
    check("R1", led_a_n, 1'b1);
    check("R1", led_b_n, 1'b1);
    @(negedge clk);
    check("R1", led_a_n, 1'b1);
    check("R1", led_b_n, 1'b1);
    rst_n = 1'b1;
    prev_ph = 3'd0;
    k_fault = 0;
  endtask

  task automatic hold(input logic m, input logic [2:0] p, input int n);
    for (int i = 0; i < n; i++) cyc(m, p, "");
  endtask

  task automatic random_run(input logic m, input int segs);
    for (int s = 0; s < segs; s++) begin
      logic [2:0] p;
      int n;
      p = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) p = 3'd4;
      n = $urandom_range(1, 3*HALF);
      hold(m, p, n);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // Single mode, directed
    cyc(1'b0, 3'd0, "");
    cyc(1'b0, 3'd1, "R10");   // change visible one edge later
    cyc(1'b0, 3'd2, "R2");
    cyc(1'b0, 3'd3, "R10");
    for (int p = 5; p < 8; p++) cyc(1'b0, 3'(p), "R2");
    hold(1'b0, 3'd4, 2*HALF + 5);          // R4 full periods
    hold(1'b0, 3'd1, 3);
    hold(1'b0, 3'd4, HALF + 3);            // into unlit half
    hold(1'b0, 3'd6, 2);
    hold(1'b0, 3'd4, 2*HALF);              // R5 restart at lit half
    random_run(1'b0, 40);

    // Fault straight out of reset restarts lit (R5)
    do_reset();
    hold(1'b0, 3'd4, HALF + 2);

    // Bicolour mode
    do_reset();
    mode_bicolor = 1'b1;
    for (int p = 0; p < 8; p++) hold(1'b1, 3'(p), 3);
    hold(1'b1, 3'd4, 2*HALF + 3);          // R7 steady
    random_run(1'b1, 40);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule